// File: doc/BRIEF.md
# Power-fail reset supervisor

This block watches a digital supply-fail flag from an analog comparator. It produces two signals. The first is a reset request for an open-drain reset pin. The second is a signal that locks the register file against access. When the supply drops below the trip point, the block pulls reset low at once and locks register access. When the supply comes back, it unlocks register access straight away. It then keeps the reset pin low for a fixed delay, counted in ticks of a 32.768 kHz reference. The default of 8192 ticks gives 250 ms.

The oscillator can be stopped while the supply is down, through an oscillator-disable configuration bit. If that bit was set at any point during the outage, the block first waits for an oscillator-stable flag. Only then does it start the delay count. The delay is therefore extended by the oscillator start-up time.

A new supply failure during the delay, or during the oscillator wait, starts the sequence again. A power-on reset follows the same path as a recovery.

The comparator flag is asynchronous and passes through a flop synchroniser. The reference tick is a single-cycle pulse in the system clock domain. The open-drain pin is built outside the block from `rst_pull_low`: the pin is driven to 0 while that output is 1, and is left undriven otherwise. The block has no output that drives the pin high.

Top module: `pf_reset_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rst_pull_low` and `access_block` are both 1. After power-on, reset is released only through the same hold sequence as a recovery.
- R2: `pf_in` is synchronised through `SYNC_STAGES` flops (default 2). A change driven before clock edge k shows on the outputs after edge k+`SYNC_STAGES`.
- R3: While the synchronised fail flag is 1, both `rst_pull_low` and `access_block` are 1 from the next cycle on.
- R4: After a recovery with the oscillator running, `access_block` is 0 from the first cycle out of the fail state. `rst_pull_low` stays 1 until exactly `HOLD_TICKS` `tick_in` pulses have been seen in the hold phase, and falls on the edge of the last of those pulses.
- R5: If `osc_off_cfg` was 1 in any cycle while the synchronised fail flag was 1, ticks are not counted until `osc_ready` has been sampled 1. Reset stays asserted during that wait.
- R6: A fail flag seen during the oscillator wait or the hold phase returns the block to the fail state. The tick count restarts from zero after the next recovery.
- R7: Once reset is released, `osc_off_cfg`, `osc_ready` and `tick_in` have no effect. The outputs stay 0 until the next supply failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| pf_in | input | 1 | Asynchronous comparator flag, 1 = supply below trip point |
| tick_in | input | 1 | Single-cycle 32.768 kHz reference tick, clk domain |
| osc_off_cfg | input | 1 | Oscillator-disable configuration bit |
| osc_ready | input | 1 | Oscillator-stable flag |
| rst_pull_low | output | 1 | 1 = pull the open-drain reset pin low; 0 = release it |
| access_block | output | 1 | 1 = register access is locked |

## Verification
The bench steps through several supply patterns:
- A clean power-on. This shows that power-on reaches the same delay path as a recovery.
- A single long outage with the oscillator left on. This separates the immediate unlock of register access from the tick-counted reset release.
- An outage during which the oscillator-disable bit is raised, with the stable flag held off well past the normal delay. This tells the extended hold apart from the plain one.
- Single-cycle fail glitches during the hold phase. These show that the count restarts rather than resumes.
- Toggling of the configuration bit, the stable flag and the tick once reset has been released. This confirms that they are ignored.

// File: rtl/pf_sup_pkg.sv
package pf_sup_pkg;
  typedef enum logic [1:0] {
    SV_DOWN     = 2'd0,
    SV_OSC_WAIT = 2'd1,
    SV_HOLD     = 2'd2,
    SV_RUN      = 2'd3
  } sup_state_t;
endpackage

// File: rtl/pf_sync_chain.sv
module pf_sync_chain #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] flop_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) flop_q[gi] <= RESET_VAL;
          else     flop_q[gi] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) flop_q[gi] <= RESET_VAL;
          else     flop_q[gi] <= flop_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_out = flop_q[LAST];
endmodule

// File: rtl/pf_hold_timer.sv
module pf_hold_timer #(
  parameter int HOLD_TICKS = 8192,
  parameter int CW         = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_active,
  input  logic          tick_in,
  output logic          timer_done,
  output logic [CW-1:0] hold_cnt
);
  localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_TICKS - 1);

  assign timer_done = hold_active && tick_in && (hold_cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst || !hold_active || timer_done) hold_cnt <= '0;
    else if (tick_in)                      hold_cnt <= hold_cnt + 1'b1;
  end
endmodule

// File: rtl/pf_sup_fsm.sv
module pf_sup_fsm
  import pf_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pf_sync,
  input  logic       osc_off_cfg,
  input  logic       osc_ready,
  input  logic       timer_done,
  output sup_state_t state,
  output logic       rst_pull_low,
  output logic       access_block
);
  sup_state_t state_d;
  logic       osc_was_off_q, osc_was_off_d;

  always_comb begin
    state_d       = state;
    osc_was_off_d = osc_was_off_q;
    if (pf_sync) begin
      state_d       = SV_DOWN;
      osc_was_off_d = osc_was_off_q | osc_off_cfg;
    end else begin
      case (state)
        SV_DOWN:     state_d = osc_was_off_q ? SV_OSC_WAIT : SV_HOLD;
        SV_OSC_WAIT: if (osc_ready) state_d = SV_HOLD;
        SV_HOLD: begin
          if (timer_done) begin
            state_d       = SV_RUN;
            osc_was_off_d = 1'b0;
          end
        end
        SV_RUN:      state_d = SV_RUN;
        default:     state_d = SV_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= SV_DOWN;
      osc_was_off_q <= 1'b0;
      rst_pull_low  <= 1'b1;
      access_block  <= 1'b1;
    end else begin
      state         <= state_d;
      osc_was_off_q <= osc_was_off_d;
      rst_pull_low  <= (state_d != SV_RUN);
      access_block  <= (state_d == SV_DOWN);
    end
  end
endmodule

// File: rtl/pf_reset_supervisor.sv
module pf_reset_supervisor
  import pf_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic pf_in,
  input  logic tick_in,
  input  logic osc_off_cfg,
  input  logic osc_ready,
  output logic rst_pull_low,
  output logic access_block
);
  localparam int CW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;

  logic          pf_sync;
  logic          timer_done;
  logic [CW-1:0] hold_cnt;
  sup_state_t    state;

  pf_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pf_in),
    .q_out (pf_sync)
  );

  pf_hold_timer #(.HOLD_TICKS(HOLD_TICKS), .CW(CW)) timer_i (
    .clk         (clk),
    .rst         (rst),
    .hold_active (state == SV_HOLD),
    .tick_in     (tick_in),
    .timer_done  (timer_done),
    .hold_cnt    (hold_cnt)
  );

  pf_sup_fsm fsm_i (
    .clk          (clk),
    .rst          (rst),
    .pf_sync      (pf_sync),
    .osc_off_cfg  (osc_off_cfg),
    .osc_ready    (osc_ready),
    .timer_done   (timer_done),
    .state        (state),
    .rst_pull_low (rst_pull_low),
    .access_block (access_block)
  );
endmodule

// File: rtl/pf_reset_supervisor_chk.sv
module pf_reset_supervisor_chk
  import pf_sup_pkg::*;
#(
  parameter int HOLD_TICKS = 8192,
  parameter int CW         = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          pf_sync,
  input logic          osc_ready,
  input logic          timer_done,
  input logic [CW-1:0] hold_cnt,
  input sup_state_t    state,
  input logic          rst_pull_low,
  input logic          access_block
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rst_pull_low && access_block));

  a_r3_fail_asserts: assert property (@(posedge clk) disable iff (rst)
    pf_sync |=> (rst_pull_low && access_block));

  a_r3_block_implies_reset: assert property (@(posedge clk) disable iff (rst)
    access_block |-> rst_pull_low);

  a_r4_release_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pull_low) |-> $past(timer_done));

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= CW'(HOLD_TICKS - 1));

  a_r5_wait_holds_reset: assert property (@(posedge clk) disable iff (rst)
    (state == SV_OSC_WAIT && !osc_ready && !pf_sync) |=> (state == SV_OSC_WAIT && rst_pull_low));

  a_r7_run_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == SV_RUN && !pf_sync) |=> (!rst_pull_low && !access_block));
endmodule

bind pf_reset_supervisor pf_reset_supervisor_chk #(.HOLD_TICKS(HOLD_TICKS), .CW(CW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .pf_sync      (pf_sync),
  .osc_ready    (osc_ready),
  .timer_done   (timer_done),
  .hold_cnt     (hold_cnt),
  .state        (state),
  .rst_pull_low (rst_pull_low),
  .access_block (access_block)
);

// File: tb/pf_reset_supervisor_tb_top.sv
module pf_reset_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HT         = 12;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pf_in = 1'b1;
  logic tick_in = 1'b0;
  logic osc_off_cfg = 1'b0;
  logic osc_ready = 1'b1;
  logic rst_pull_low, access_block;
  logic tick_en = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_reset_supervisor #(.SYNC_STAGES(2), .HOLD_TICKS(HT)) dut_i (
    .clk, .rst, .pf_in, .tick_in, .osc_off_cfg, .osc_ready,
    .rst_pull_low, .access_block
  );

  // Behavioural reference: 0 fail, 1 osc wait, 2 hold, 3 released
  int  m_st = 0;
  int  m_cnt = 0;
  bit  m_off = 0;
  bit  m_q [$];

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_off = 0;
      m_q = {1'b1, 1'b1};
    end else begin
      if (m_q[1]) begin
        m_st = 0; m_cnt = 0; m_off = m_off | osc_off_cfg;
      end else if (m_st == 0) begin
        m_st = m_off ? 1 : 2; m_cnt = 0;
      end else if (m_st == 1) begin
        if (osc_ready) m_st = 2;
      end else if (m_st == 2) begin
        if (tick_in) begin
          if (m_cnt == HT - 1) begin m_st = 3; m_cnt = 0; m_off = 0; end
          else m_cnt++;
        end
      end
      m_q.push_front(pf_in);
      void'(m_q.pop_back());
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, sampled at negedge
  always @(negedge clk) begin
    if (!rst) begin
      string tag;
      case (m_st)
        0: tag = "R3";
        1: tag = "R5";
        2: tag = "R4";
        default: tag = "R7";
      endcase
      check(tag, rst_pull_low, (m_st != 3), "model rst_pull_low");
      check(tag, access_block, (m_st == 0), "model access_block");
    end
  end

  // tick generator
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      tick_in = tick_en && (n % TICK_DIV == 0);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam int HOLD_CYC = HT * TICK_DIV + 8;

  initial begin
    cyc(3);
    check("R1", rst_pull_low, 1'b1, "reset rst_pull_low");
    check("R1", access_block, 1'b1, "reset access_block");
    pf_in = 1'b0;
    rst = 1'b0;
    cyc(1);
    check("R1", rst_pull_low, 1'b1, "first cycle after reset");
    cyc(HOLD_CYC / 2);
    check("R1", rst_pull_low, 1'b1, "power-on still holding");
    cyc(HOLD_CYC);
    check("R1", rst_pull_low, 1'b0, "power-on released");

    // R2 latency: two sync flops then state register
    pf_in = 1'b1;
    cyc(1);
    check("R2", access_block, 1'b0, "after 1 edge");
    cyc(1);
    check("R2", access_block, 1'b0, "after 2 edges");
    cyc(1);
    check("R2", access_block, 1'b1, "after 3 edges");
    check("R3", rst_pull_low, 1'b1, "fail drives low");
    cyc(20);
    pf_in = 1'b0;
    cyc(4);
    check("R4", access_block, 1'b0, "access unlocked on recovery");
    check("R4", rst_pull_low, 1'b1, "hold active");
    cyc(HOLD_CYC);
    check("R4", rst_pull_low, 1'b0, "released after hold");

    // R5: oscillator disabled during outage
    pf_in = 1'b1;
    cyc(5);
    osc_off_cfg = 1'b1;
    osc_ready = 1'b0;
    cyc(3);
    osc_off_cfg = 1'b0;
    cyc(5);
    pf_in = 1'b0;
    cyc(3 * HOLD_CYC);
    check("R5", rst_pull_low, 1'b1, "waiting for oscillator");
    check("R5", access_block, 1'b0, "access open during osc wait");
    osc_ready = 1'b1;
    cyc(HOLD_CYC / 2);
    check("R5", rst_pull_low, 1'b1, "hold after osc start");
    cyc(HOLD_CYC);
    check("R5", rst_pull_low, 1'b0, "released after osc + hold");

    // R6: glitch during hold restarts count
    pf_in = 1'b1;
    cyc(6);
    pf_in = 1'b0;
    cyc(HOLD_CYC - 20);
    pf_in = 1'b1;
    cyc(1);
    pf_in = 1'b0;
    cyc(22);
    check("R6", rst_pull_low, 1'b1, "restart extends hold");
    cyc(HOLD_CYC);
    check("R6", rst_pull_low, 1'b0, "released after restarted hold");

    // R7: inputs ignored when released
    osc_off_cfg = 1'b1;
    osc_ready = 1'b0;
    cyc(10);
    tick_en = 1'b0;
    osc_ready = 1'b1;
    cyc(10);
    tick_en = 1'b1;
    osc_off_cfg = 1'b0;
    cyc(5);
    check("R7", rst_pull_low, 1'b0, "ignored inputs, reset");
    check("R7", access_block, 1'b0, "ignored inputs, access");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule